// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a periodic interval timer for a small processor. Software places a reload value in two byte-wide holding registers. A command bit copies that value into a 16-bit down-counter. While the timer runs, a prescaler turns the processor clock into a count enable, either one pulse every 16 clocks or one pulse every 2 clocks. Each enable moves the counter one step down.

When a step would take the count to zero, the counter instead takes the holding value again and raises a time-out flag. The interrupt output follows that flag while the timer runs, so a program can poll the flag or take the interrupt. Reads of the two count addresses return the live count, not the holding value. The flag clears when software writes a one to it or when it stops the timer.

The processor side uses a single-cycle synchronous register bus: `bus_sel` with `bus_we` high writes `bus_wdata` at the clock edge, and `bus_rdata` shows the selected register combinationally. Reads have no side effects.

Top module: `interval_timer`

## Requirements
- R1: Reset is active low and synchronous. After reset, every register reads 0x00 and `irq` is low.
- R2: Writes to address 0 (low byte) and address 1 (high byte) go only to the holding registers. The live count does not change because of them.
- R3: Reads of address 0 and address 1 return bits 7:0 and 15:8 of the live count.
- R4: A write to the control register (address 2) with bit 6 set copies the holding value into the counter and zeroes the prescaler at that edge. Bit 6 always reads back as 0.
- R5: Control bit 7 is the run bit. While it is 1 the count steps down from its present value. While it is 0 the count holds.
- R6: Control bit 5 selects the rate. With 0, the count steps once every 16 clocks. With 1, it steps once every 2 clocks. After a load, the first step falls that many clocks after the load edge.
- R7: A step that finds the count at 1 or at 0 reloads the holding value and sets the time-out flag. A holding value of N gives one time-out every N steps. A holding value of 0 gives a time-out on every step.
- R8: Writing status (address 3) with bit 7 set clears the time-out flag, which reads at status bit 7. Writing 0 there has no effect. If a clear and a time-out fall on the same edge, the flag stays set.
- R9: A control write with bit 7 clear clears the time-out flag and drops `irq`.
- R10: `irq` is high exactly when the time-out flag is set and the timer is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address (0 count/hold low, 1 count/hold high, 2 control, 3 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Time-out interrupt level |

## Verification
The assertions assume that each clock carries at most one bus access. They also assume that `bus_addr` and `bus_wdata` are stable and known whenever `bus_sel` is high. The bench keeps to this by changing the bus only on falling edges and holding each write for exactly one rising edge. It returns `bus_sel` low between accesses. Reads are made with `bus_we` low between edges, so they never land on the same edge as a write.

// File: rtl/itmr_pkg.sv
// Package: address map and bit positions shared by the interval timer blocks.
// Assumes a data path at least eight bits wide.
package itmr_pkg;
    localparam logic [1:0] ADDR_CNT_LO = 2'd0;
    localparam logic [1:0] ADDR_CNT_HI = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_STAT   = 2'd3;

    localparam int BIT_RUN  = 7;
    localparam int BIT_LOAD = 6;
    localparam int BIT_FAST = 5;
    localparam int BIT_FLAG = 7;
endpackage

// File: rtl/itmr_regs.sv
// Register file: holding registers and control bits, plus single-cycle
// command pulses decoded from bus writes (load, stop, flag clear).
// Assumes at most one bus access per cycle.
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  hold_q,
    output logic              run_q,
    output logic              fast_q,
    output logic              load_p,
    output logic              stop_p,
    output logic              clr_p
);
    logic wr_lo, wr_hi, wr_ctrl, wr_stat;

    // Decode write strobes and command pulses.
    always_comb begin
        wr_lo   = bus_sel && bus_we && (bus_addr == ADDR_CNT_LO);
        wr_hi   = bus_sel && bus_we && (bus_addr == ADDR_CNT_HI);
        wr_ctrl = bus_sel && bus_we && (bus_addr == ADDR_CTRL);
        wr_stat = bus_sel && bus_we && (bus_addr == ADDR_STAT);
        load_p  = wr_ctrl && bus_wdata[BIT_LOAD];
        stop_p  = wr_ctrl && !bus_wdata[BIT_RUN];
        clr_p   = wr_stat && bus_wdata[BIT_FLAG];
    end

    // Holding registers for the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            if (wr_lo) hold_q[DATA_W-1:0]     <= bus_wdata;
            if (wr_hi) hold_q[CNT_W-1:DATA_W] <= bus_wdata;
        end
    end

    // Run and rate-select control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            fast_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q  <= bus_wdata[BIT_RUN];
            fast_q <= bus_wdata[BIT_FAST];
        end
    end
endmodule

// File: rtl/itmr_prescaler.sv
// Prescaler: divides the clock by DIV_SLOW or DIV_FAST while running and
// emits a one-cycle step enable. A clear request restarts it from zero.
// Assumes DIV_SLOW >= DIV_FAST >= 1.
module itmr_prescaler #(
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 2,
    localparam int PRE_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    input  logic clear,
    output logic tick
);
    localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);
    localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Select the terminal value and flag the step enable.
    always_comb begin
        limit = fast ? LIM_FAST : LIM_SLOW;
        tick  = run && (pre_q >= limit);
    end

    // Phase counter: clears on load or wrap and holds while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_counter.sv
// Down-counter: loads on command and steps down on each enable. A step that
// finds 1 or 0 reloads the holding value and reports a time-out.
module itmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] hold,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tout
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Time-out detection; a load on the same edge takes priority.
    always_comb begin
        tout = tick && !load && (cnt_q <= ONE);
    end

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || tout) begin
            cnt_q <= hold;
        end else if (tick) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/itmr_status.sv
// Time-out flag with stop-clear and write-one-clear; interrupt gated by run.
// Priority: stop clears, then a new time-out sets, then the write-one clear.
module itmr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic tout,
    input  logic clr,
    input  logic run,
    output logic flag_q,
    output logic irq
);
    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            flag_q <= 1'b0;
        end else if (tout) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt level.
    always_comb begin
        irq = flag_q && run;
    end
endmodule

// File: rtl/interval_timer.sv
// Interval timer top: register bus, prescaler, down-counter and time-out
// status. Reads are combinational and free of side effects.
module interval_timer
    import itmr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_SLOW = 16,
    parameter int DIV_FAST = 2,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic run_q, fast_q, load_p, stop_p, clr_p;
    logic tick, tout, flag_q;

    itmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hold_q(hold_q),
        .run_q(run_q), .fast_q(fast_q), .load_p(load_p), .stop_p(stop_p),
        .clr_p(clr_p)
    );

    itmr_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .fast(fast_q),
        .clear(load_p), .tick(tick)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_p), .tick(tick),
        .hold(hold_q), .cnt_q(cnt_q), .tout(tout)
    );

    itmr_status u_stat (
        .clk(clk), .rst_n(rst_n), .stop(stop_p), .tout(tout), .clr(clr_p),
        .run(run_q), .flag_q(flag_q), .irq(irq)
    );

    // Read multiplexer; the load bit always reads back as zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
            ADDR_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
            ADDR_CTRL: begin
                bus_rdata[BIT_RUN]  = run_q;
                bus_rdata[BIT_FAST] = fast_q;
            end
            default: bus_rdata[BIT_FLAG] = flag_q;
        endcase
    end
endmodule

// File: rtl/itmr_checker.sv
// Checker for the interval timer, bound into every instance of the top.
module itmr_checker
    import itmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  hold,
    input logic              tick,
    input logic              tout,
    input logic              flag
);
    logic wr_ctrl, wr_stat, wr_ld;
    assign wr_ctrl = bus_sel && bus_we && (bus_addr == ADDR_CTRL);
    assign wr_stat = bus_sel && bus_we && (bus_addr == ADDR_STAT);
    assign wr_ld   = wr_ctrl && bus_wdata[BIT_LOAD];

    // R4
    load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ld |=> (cnt == $past(hold)));

    // R2
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ld && !tick) |=> $stable(cnt));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_ld && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R7
    tout_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tout && !(wr_ctrl && !bus_wdata[BIT_RUN])) |=> (flag && cnt == $past(hold)));

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[BIT_FLAG] && !tout) |=> !flag);

    // R8
    w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !bus_wdata[BIT_FLAG] && flag) |=> flag);

    // R9
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[BIT_RUN]) |=> (!irq && !flag));

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind interval_timer itmr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .cnt(cnt_q),
    .hold(hold_q), .tick(tick), .tout(tout), .flag(flag_q)
);

// File: tb/interval_timer_test.sv
// Directed bench for the interval timer: one task per scenario.
`timescale 1ns/1ps
module interval_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    interval_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_sel = 1'b1; bus_we = 1'b0;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, bus_rdata, exp);
        end
        bus_sel = 1'b0;
    endtask

    task automatic check_irq(input logic exp, input string req);
        checks++;
        if (irq !== exp) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
        end
    endtask

    task automatic check_count(input logic [15:0] exp, input string req);
        check_reg(2'd0, exp[7:0], req);
        check_reg(2'd1, exp[15:8], req);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 4; a++) check_reg(2'(a), 8'h00, "R1");
        check_irq(1'b0, "R1");
    endtask

    task automatic t_hold_and_load;
        bus_write(2'd0, 8'h34);
        bus_write(2'd1, 8'h12);
        check_count(16'h0000, "R2");
        bus_write(2'd2, 8'h40);          // load only, not running
        check_count(16'h1234, "R3");
        check_reg(2'd2, 8'h00, "R4");     // load bit self-clears
        wait_edges(20);
        check_count(16'h1234, "R5");     // stopped: no steps
    endtask

    task automatic t_fast;
        bus_write(2'd0, 8'h05);
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'hE0);          // run, load, fast at E0
        check_reg(2'd2, 8'hA0, "R5");
        wait_edges(6);                   // steps at E2, E4, E6
        check_count(16'd2, "R6");
        wait_edges(3);                   // E9
        check_count(16'd1, "R7");
        check_reg(2'd3, 8'h00, "R7");
        wait_edges(1);                   // E10: time-out and reload
        check_count(16'd5, "R7");
        check_reg(2'd3, 8'h80, "R7");
        check_irq(1'b1, "R10");
        bus_write(2'd3, 8'h00);          // writing zero does nothing
        check_reg(2'd3, 8'h80, "R8");
        bus_write(2'd3, 8'h80);          // write one clears
        check_reg(2'd3, 8'h00, "R8");
        check_irq(1'b0, "R8");
    endtask

    task automatic t_slow_and_stop;
        bus_write(2'd0, 8'h03);
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'hC0);          // run, load, slow at E0
        wait_edges(15);
        check_count(16'd3, "R6");        // no step before E16
        wait_edges(17);                  // steps at E16, E32
        check_count(16'd1, "R6");
        wait_edges(15);                  // E47
        check_reg(2'd3, 8'h00, "R7");
        wait_edges(1);                   // E48
        check_reg(2'd3, 8'h80, "R7");
        check_count(16'd3, "R7");
        check_irq(1'b1, "R10");
        bus_write(2'd2, 8'h00);          // stop
        check_reg(2'd3, 8'h00, "R9");
        check_irq(1'b0, "R9");
        check_count(16'd3, "R5");
        wait_edges(40);
        check_count(16'd3, "R5");
    endtask

    task automatic t_zero_hold;
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'hE0);          // E0
        wait_edges(1);
        check_reg(2'd3, 8'h00, "R7");
        wait_edges(1);                   // E2: step on zero
        check_reg(2'd3, 8'h80, "R7");
        check_count(16'd0, "R7");
        bus_write(2'd3, 8'h80);          // E3
        check_reg(2'd3, 8'h00, "R8");
        wait_edges(1);                   // E4
        check_reg(2'd3, 8'h80, "R7");
    endtask

    task automatic t_clear_collision;
        bus_write(2'd2, 8'h00);          // stop, clears flag
        bus_write(2'd0, 8'h04);
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'hE0);          // E0
        wait_edges(8);                   // E8 time-out
        check_reg(2'd3, 8'h80, "R7");
        bus_write(2'd3, 8'h80);          // E9
        check_reg(2'd3, 8'h00, "R8");
        wait_edges(6);                   // E15
        bus_write(2'd3, 8'h80);          // E16 clashes with time-out
        check_reg(2'd3, 8'h80, "R8");
        check_irq(1'b1, "R10");
    endtask

    initial begin
        wait_edges(3);
        rst_n = 1'b1;
        t_reset();
        t_hold_and_load();
        t_fast();
        t_slow_and_stop();
        t_zero_hold();
        t_clear_collision();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule